// File: doc/BRIEF.md
# Dual-Page-Size Address Translation Buffer

This block caches 32 virtual-to-physical page translations and answers a lookup in the same cycle the virtual address is presented. Because the answer is combinational, a surrounding pipeline can index a cache with the untranslated low address bits while the translation is being formed. Every stored translation is compared against the incoming address at once. Any translation may sit in any slot.

Each slot maps either a small 4 KB page or a large 4 MB page. A small page compares the upper 20 address bits and keeps the low 12 bits unchanged. A large page compares only the upper 10 bits and keeps the low 22 bits unchanged. After a miss, the requester installs a new translation through the fill port. The fill uses the lowest empty slot if one exists. Otherwise it replaces the slot chosen by a binary-tree pseudo-LRU state. A flush input empties the whole buffer in one cycle.

Top module: `tlbx_xlate`

## Requirements
- R1: The buffer holds 32 translations. Any 32 distinct page mappings can be resident together, and all of them then hit.
- R2: A valid small-page slot (page-size flag 0) matches when its stored tag equals virtual bits 31..12. The physical address is then {frame[19:0], va[11:0]}.
- R3: A valid large-page slot (page-size flag 1) matches when tag bits 19..10 equal virtual bits 31..22. The physical address is then {frame[19:10], va[21:0]}.
- R4: Lookup results are combinational, in the same cycle as the address. With `lk_valid` high, `lk_hit` is 1 on a match and `lk_miss` is 1 otherwise. With `lk_valid` low, both are 0 and `lk_paddr` is 0.
- R5: When any slot is empty, a fill writes the lowest-numbered empty slot.
- R6: When all slots are full, a fill replaces the victim chosen by a 31-bit tree. Node 0 is the root, and the children of node n are 2n+1 and 2n+2. Bit value 0 steers the search to the lower half, and the slot index is read MSB first along the path. On every hit and every fill, each node on the path to the used slot is set to steer away from it.
- R7: If several slots match, `lk_multi` is 1 and the lowest-numbered matching slot supplies the translation and the replacement update.
- R8: A flush empties every slot and zeroes the tree in one cycle. A flush takes priority over a fill in the same cycle, so that fill is dropped.
- R9: After reset, the buffer is empty (every lookup misses) and the tree is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Lookup found a translation |
| lk_miss | output | 1 | Lookup found no translation |
| lk_multi | output | 1 | More than one slot matched |
| lk_paddr | output | 32 | Translated physical address |
| fill_en | input | 1 | Install a translation this cycle |
| fill_vaddr | input | 32 | Virtual address of the page being installed |
| fill_big | input | 1 | 1 = 4 MB page, 0 = 4 KB page |
| fill_frame | input | 20 | Physical frame number (upper 10 bits for a large page) |
| flush | input | 1 | Invalidate every slot and reset replacement state |

## Verification
The replacement order is the most fragile part. The bench fills the buffer completely, keeps going, and checks that exactly the page its own tree model predicts has gone. A design that updated the wrong tree node, or skipped the update on hits, would evict a live page, and a later lookup of that page would miss. The bench sets up a small page inside a large page, so two slots match. A wrong priority encoder would return the other frame or leave the multi-match flag low. Flushes are checked alone and together with a fill: a design that let the fill through would still hit afterwards.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

    localparam int VA_W      = 32;
    localparam int SMALL_OFF = 12;
    localparam int BIG_OFF   = 22;
    localparam int TAG_W     = VA_W - SMALL_OFF;
    localparam int FRAME_W   = 20;
    localparam int PA_W      = FRAME_W + SMALL_OFF;
    localparam int BIG_TAG_W = VA_W - BIG_OFF;
    localparam int BIG_FRM_W = PA_W - BIG_OFF;

    typedef struct packed {
        logic               valid;
        logic               big;
        logic [TAG_W-1:0]   vtag;
        logic [FRAME_W-1:0] frame;
    } tlb_slot_t;

    function automatic logic slot_hits(tlb_slot_t s, logic [VA_W-1:0] va);
        logic small_eq;
        logic big_eq;
        small_eq = (s.vtag == va[VA_W-1:SMALL_OFF]);
        big_eq   = (s.vtag[TAG_W-1 -: BIG_TAG_W] == va[VA_W-1:BIG_OFF]);
        return s.valid && (s.big ? big_eq : small_eq);
    endfunction

    function automatic logic [PA_W-1:0] slot_xlate(tlb_slot_t s, logic [VA_W-1:0] va);
        if (s.big)
            return {s.frame[FRAME_W-1 -: BIG_FRM_W], va[BIG_OFF-1:0]};
        return {s.frame, va[SMALL_OFF-1:0]};
    endfunction

endpackage

// File: rtl/tlbx_match.sv
module tlbx_match
    import tlbx_pkg::*;
#(
    parameter int N_SLOTS = 32,
    parameter int IDX_W   = $clog2(N_SLOTS)
) (
    input  tlb_slot_t        slots [N_SLOTS],
    input  logic [VA_W-1:0]  va,
    output logic             any_hit,
    output logic             multi_hit,
    output logic [IDX_W-1:0] hit_idx
);

    logic [N_SLOTS-1:0] hit_vec;

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_cmp
        assign hit_vec[g] = slot_hits(slots[g], va);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = N_SLOTS - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    assign any_hit   = |hit_vec;
    assign multi_hit = |(hit_vec & (hit_vec - 1'b1));

endmodule

// File: rtl/tlbx_plru.sv
module tlbx_plru #(
    parameter int N_SLOTS = 32,
    parameter int IDX_W   = $clog2(N_SLOTS),
    localparam int NODES  = N_SLOTS - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] victim
);

    logic [NODES-1:0] tree_q;
    logic [NODES-1:0] tree_d;

    always_comb begin
        int node;
        node   = 0;
        victim = '0;
        for (int lvl = 0; lvl < IDX_W; lvl++) begin
            victim[IDX_W-1-lvl] = tree_q[node];
            node = 2 * node + 1 + int'(tree_q[node]);
        end
    end

    always_comb begin
        int node;
        logic dir;
        node   = 0;
        tree_d = tree_q;
        for (int lvl = 0; lvl < IDX_W; lvl++) begin
            dir          = touch_idx[IDX_W-1-lvl];
            tree_d[node] = ~dir;
            node         = 2 * node + 1 + int'(dir);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr)    tree_q <= '0;
        else if (touch_en) tree_q <= tree_d;
    end

    assert_away_from_used_R6: assert property (@(posedge clk) disable iff (rst)
        (touch_en && !clr) |=> (victim != $past(touch_idx)));

    assert_clear_points_low_R8: assert property (@(posedge clk) disable iff (rst)
        clr |=> (victim == '0));

endmodule

// File: rtl/tlbx_store.sv
module tlbx_store
    import tlbx_pkg::*;
#(
    parameter int N_SLOTS = 32,
    parameter int IDX_W   = $clog2(N_SLOTS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic               fill_en,
    input  logic [VA_W-1:0]    fill_vaddr,
    input  logic               fill_big,
    input  logic [FRAME_W-1:0] fill_frame,
    input  logic [IDX_W-1:0]   plru_victim,
    output tlb_slot_t          slots [N_SLOTS],
    output logic               fill_go,
    output logic [IDX_W-1:0]   fill_idx
);

    logic [N_SLOTS-1:0] valid_vec;
    logic               have_free;
    logic [IDX_W-1:0]   free_idx;
    tlb_slot_t          new_slot;

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_vld
        assign valid_vec[g] = slots[g].valid;
    end

    always_comb begin
        free_idx = '0;
        for (int i = N_SLOTS - 1; i >= 0; i--) begin
            if (!valid_vec[i]) free_idx = IDX_W'(i);
        end
    end

    assign have_free = ~&valid_vec;
    assign fill_idx  = have_free ? free_idx : plru_victim;
    assign fill_go   = fill_en && !flush;

    always_comb begin
        new_slot.valid = 1'b1;
        new_slot.big   = fill_big;
        new_slot.vtag  = fill_vaddr[VA_W-1:SMALL_OFF];
        new_slot.frame = fill_frame;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < N_SLOTS; i++) slots[i] <= '0;
        end else if (fill_go) begin
            slots[fill_idx] <= new_slot;
        end
    end

    assert_fill_takes_free_R5: assert property (@(posedge clk) disable iff (rst)
        (fill_en && have_free) |-> !valid_vec[fill_idx]);

    assert_fill_lands_R1: assert property (@(posedge clk) disable iff (rst)
        fill_go |=> valid_vec[$past(fill_idx)]);

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_vec == '0));

endmodule

// File: rtl/tlbx_xlate.sv
module tlbx_xlate
    import tlbx_pkg::*;
#(
    parameter int N_SLOTS = 32,
    localparam int IDX_W  = $clog2(N_SLOTS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                lk_valid,
    input  logic [31:0]         lk_vaddr,
    output logic                lk_hit,
    output logic                lk_miss,
    output logic                lk_multi,
    output logic [31:0]         lk_paddr,
    input  logic                fill_en,
    input  logic [31:0]         fill_vaddr,
    input  logic                fill_big,
    input  logic [19:0]         fill_frame,
    input  logic                flush
);

    tlb_slot_t        slots [N_SLOTS];
    logic             any_hit;
    logic             multi_hit;
    logic [IDX_W-1:0] hit_idx;
    logic [IDX_W-1:0] victim;
    logic [IDX_W-1:0] fill_idx;
    logic             fill_go;
    logic             touch_en;
    logic [IDX_W-1:0] touch_idx;

    tlbx_store #(.N_SLOTS(N_SLOTS)) u_store (
        .clk         (clk),
        .rst         (rst),
        .flush       (flush),
        .fill_en     (fill_en),
        .fill_vaddr  (fill_vaddr),
        .fill_big    (fill_big),
        .fill_frame  (fill_frame),
        .plru_victim (victim),
        .slots       (slots),
        .fill_go     (fill_go),
        .fill_idx    (fill_idx)
    );

    tlbx_match #(.N_SLOTS(N_SLOTS)) u_match (
        .slots     (slots),
        .va        (lk_vaddr),
        .any_hit   (any_hit),
        .multi_hit (multi_hit),
        .hit_idx   (hit_idx)
    );

    assign lk_hit   = lk_valid && any_hit;
    assign lk_miss  = lk_valid && !any_hit;
    assign lk_multi = lk_valid && multi_hit;
    assign lk_paddr = lk_hit ? slot_xlate(slots[hit_idx], lk_vaddr) : '0;

    assign touch_en  = fill_go || lk_hit;
    assign touch_idx = fill_go ? fill_idx : hit_idx;

    tlbx_plru #(.N_SLOTS(N_SLOTS)) u_plru (
        .clk       (clk),
        .rst       (rst),
        .clr       (flush),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .victim    (victim)
    );

    assert_offset_kept_R2: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (lk_paddr[SMALL_OFF-1:0] == lk_vaddr[SMALL_OFF-1:0]));

    assert_multi_is_hit_R7: assert property (@(posedge clk) disable iff (rst)
        lk_multi |-> lk_hit);

    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> (!lk_hit && !lk_miss && lk_paddr == '0));

    assert_no_hit_after_flush_R8: assert property (@(posedge clk) disable iff (rst)
        flush |=> !lk_hit);

endmodule

// File: tb/tlbx_xlate_bench.sv
module tlbx_xlate_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        lk_valid;
    logic [31:0] lk_vaddr;
    logic        lk_hit;
    logic        lk_miss;
    logic        lk_multi;
    logic [31:0] lk_paddr;
    logic        fill_en;
    logic [31:0] fill_vaddr;
    logic        fill_big;
    logic [19:0] fill_frame;
    logic        flush;

    always #2.5 clk = ~clk;

    tlbx_xlate u_tlbx_xlate (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_multi(lk_multi), .lk_paddr(lk_paddr),
        .fill_en(fill_en), .fill_vaddr(fill_vaddr), .fill_big(fill_big),
        .fill_frame(fill_frame), .flush(flush)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic        m_valid [32];
    logic        m_big   [32];
    logic [19:0] m_tag   [32];
    logic [19:0] m_frame [32];
    logic [30:0] m_tree;

    logic [31:0] pool [64];
    int          npool = 0;

    function automatic bit m_match(int i, logic [31:0] va);
        if (!m_valid[i]) return 1'b0;
        if (m_big[i]) return m_tag[i][19:10] == va[31:22];
        return m_tag[i] == va[31:12];
    endfunction

    function automatic logic [31:0] m_xlate(int i, logic [31:0] va);
        if (m_big[i]) return {m_frame[i][19:10], va[21:0]};
        return {m_frame[i], va[11:0]};
    endfunction

    function automatic int m_victim();
        int node = 0;
        int idx  = 0;
        for (int l = 0; l < 5; l++) begin
            idx  = idx * 2 + int'(m_tree[node]);
            node = 2 * node + 1 + int'(m_tree[node]);
        end
        return idx;
    endfunction

    task automatic m_touch(int idx);
        int node = 0;
        for (int l = 0; l < 5; l++) begin
            bit d = idx[4-l];
            m_tree[node] = ~d;
            node = 2 * node + 1 + int'(d);
        end
    endtask

    task automatic m_clear();
        for (int i = 0; i < 32; i++) m_valid[i] = 1'b0;
        m_tree = '0;
    endtask

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_lookup(logic [31:0] va, string req);
        int          first = -1;
        int          cnt   = 0;
        logic [31:0] exp_pa;
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; fill_en = 1'b0; flush = 1'b0;
        #1;
        for (int i = 0; i < 32; i++) begin
            if (m_match(i, va)) begin
                cnt++;
                if (first < 0) first = i;
            end
        end
        exp_pa = (first >= 0) ? m_xlate(first, va) : 32'h0;
        check(lk_hit == (cnt > 0) && lk_miss == (cnt == 0) &&
              lk_multi == (cnt > 1) && lk_paddr == exp_pa, req,
              {29'h0, lk_hit, lk_miss, lk_multi, lk_paddr},
              {29'h0, cnt > 0, cnt == 0, cnt > 1, exp_pa});
        if (first >= 0) m_touch(first);
    endtask

    task automatic do_fill(logic [31:0] va, bit big, logic [19:0] frm, bit with_flush);
        int idx = -1;
        @(negedge clk);
        lk_valid = 1'b0; fill_en = 1'b1; fill_vaddr = va; fill_big = big;
        fill_frame = frm; flush = with_flush;
        if (with_flush) begin
            m_clear();
        end else begin
            for (int i = 31; i >= 0; i--) if (!m_valid[i]) idx = i;
            if (idx < 0) idx = m_victim();
            m_valid[idx] = 1'b1; m_big[idx] = big;
            m_tag[idx] = va[31:12]; m_frame[idx] = frm;
            m_touch(idx);
        end
    endtask

    task automatic do_flush();
        @(negedge clk);
        lk_valid = 1'b0; fill_en = 1'b0; flush = 1'b1;
        m_clear();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 1, 0);
        finish_run();
    end

    initial begin
        int victim;
        void'($urandom(32'd1234));
        rst = 1'b1; lk_valid = 1'b0; lk_vaddr = '0; fill_en = 1'b0;
        fill_vaddr = '0; fill_big = 1'b0; fill_frame = '0; flush = 1'b0;
        m_clear();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R9: empty after reset
        do_lookup(32'h0000_0000, "R9 reset miss");
        do_lookup(32'hDEAD_BEEF, "R9 reset miss");

        // R4: idle lookup port is quiet
        @(negedge clk); lk_valid = 1'b0; lk_vaddr = 32'h1234_5678; #1;
        check(!lk_hit && !lk_miss && lk_paddr == 0, "R4 idle outputs",
              {31'h0, lk_hit, lk_miss, lk_paddr}, 64'h0);

        // R2: small page
        do_fill(32'h1234_5000, 1'b0, 20'hABCDE, 1'b0);
        do_lookup(32'h1234_5678, "R2 small hit");
        do_lookup(32'h1234_6678, "R2 small neighbour miss");
        @(negedge clk); lk_valid = 1'b1; lk_vaddr = 32'h1234_5FFF; #1;
        check(lk_paddr == 32'hABCD_EFFF, "R2 small paddr", {32'h0, lk_paddr}, 64'hABCD_EFFF);
        m_touch(0);

        // R3: large page
        do_fill(32'h4000_0000, 1'b1, 20'h55500, 1'b0);
        do_lookup(32'h4012_3456, "R3 large hit");
        do_lookup(32'h403F_FFFF, "R3 large top");
        do_lookup(32'h4040_0000, "R3 large next miss");

        // R7: small page inside large page, large one at lower slot
        do_fill(32'h4010_0000, 1'b0, 20'h77777, 1'b0);
        do_lookup(32'h4010_0ABC, "R7 multi lowest slot");
        @(negedge clk); lk_valid = 1'b1; lk_vaddr = 32'h4010_0ABC; #1;
        check(lk_multi && lk_paddr == 32'h5550_0ABC, "R7 multi flag and frame",
              {31'h0, lk_multi, lk_paddr}, {31'h0, 1'b1, 32'h5550_0ABC});
        m_touch(1);

        // R8: flush, and flush beating a fill
        do_flush();
        do_lookup(32'h1234_5678, "R8 flushed miss");
        do_lookup(32'h4012_3456, "R8 flushed miss");
        do_fill(32'h9999_9000, 1'b0, 20'h11111, 1'b1);
        do_lookup(32'h9999_9000, "R8 flush beats fill");

        // R1/R5: fill all 32 slots, all resident
        for (int i = 0; i < 32; i++)
            do_fill({12'h100 + 12'(i), 8'h0, 12'h0}, 1'b0, 20'(i * 3 + 5), 1'b0);
        for (int i = 0; i < 32; i++)
            do_lookup({12'h100 + 12'(i), 8'h0, 12'h123}, "R1 all resident");

        // R6: extra fill evicts the tree victim
        victim = m_victim();
        do_fill(32'hF00F_F000, 1'b0, 20'hCAFE0, 1'b0);
        do_lookup({12'h100 + 12'(victim), 8'h0, 12'h010}, "R6 victim evicted");
        do_lookup(32'hF00F_F444, "R6 new page hit");
        for (int i = 0; i < 32; i++)
            do_lookup({12'h100 + 12'(i), 8'h0, 12'h7}, "R6 survivors");

        // Random mix, R5 duplicates land in model order
        do_flush();
        for (int n = 0; n < 3000; n++) begin
            int r = int'($urandom % 100);
            if (r < 1) begin
                do_flush();
            end else if (r < 30) begin
                logic [31:0] va = $urandom;
                bit big = ($urandom % 8) == 0;
                if (big) va[21:0] = '0; else va[11:0] = '0;
                do_fill(va, big, 20'($urandom), 1'b0);
                pool[npool % 64] = va;
                npool++;
            end else if (r < 85 && npool > 0) begin
                logic [31:0] va = pool[$urandom % ((npool < 64) ? npool : 64)];
                va[11:0] = 12'($urandom);
                do_lookup(va, "R5 R6 random resident");
            end else begin
                do_lookup($urandom, "R4 random");
            end
        end

        @(negedge clk); lk_valid = 1'b0; fill_en = 1'b0; flush = 1'b0;
        finish_run();
    end

endmodule